// File: doc/BRIEF.md
# Data-Driven Bus Clock-Gated Register

This block is a parameterised register that receives its clock only when the stored word is about to change. Every bit of the incoming word is compared with the matching stored bit by an exclusive-OR. The comparison results are OR-reduced into one change request. That request can also be qualified by an explicit enable input.

The qualified request passes through a level-sensitive latch. The latch is transparent while the clock is low and holds its value while the clock is high. The latch output is then ANDed with the clock to form the register clock. Because the latched request cannot move during the high phase, a request that changes mid-phase cannot shorten a pulse or add one.

A count of gated-clock pulses is exposed at the ports. This lets the surrounding logic or a bench see how often the register was actually clocked. The enable input may be tied high, which leaves the register purely data driven.

Top module: `dd_gated_reg`

## Requirements
- R1: When `en` is 1 at a rising clock edge and `d` differs from `q` in one or more bits, `q` takes the value of `d` at that edge.
- R2: When `d` equals `q` at a rising clock edge, `q` keeps its value and `pulse_cnt` does not advance.
- R3: `pulse_cnt` advances by exactly one for each rising clock edge at which `en` is 1 and `d` differs from `q`, and by zero at every other edge.
- R4: The gating request is captured at the rising edge. Changes of `d` while the clock is high do not add a pulse, do not cut a pulse short and do not change `q`.
- R5: When `en` is 0 at a rising clock edge, `q` and `pulse_cnt` hold, whatever the value of `d`.
- R6: Driving `rst_n` low clears `q` and `pulse_cnt` to zero at once, without waiting for any clock edge.
- R7: `pulse_cnt` is an unsigned count of `CNT_W` bits that wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; rising edge is active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Explicit enable ANDed into the gating request; tie to 1 for pure data-driven gating |
| d | input | WIDTH | Incoming word |
| q | output | WIDTH | Stored word |
| pulse_cnt | output | CNT_W | Number of gated-clock pulses since reset |

## Verification
The assertions sample at the free-running clock edge. They assume that `d` and `en` are stable across each rising edge and settle during the low phase, because the latch only sees the request while the clock is low. The table-driven stimulus changes `d` and `en` only at falling edges. The one directed test that moves `d` while the clock is high does so on purpose and returns `d` to a settled value before the next falling edge. Reset is released away from the rising edge, so that the asynchronous release never coincides with a gated pulse.

// File: rtl/dd_gated_reg.sv
module dd_gated_reg #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [CNT_W-1:0] pulse_cnt
);

  logic [WIDTH-1:0] diff;
  logic             req;
  logic             req_hold;
  logic             gclk;

  assign diff = d ^ q;
  assign req  = en & (|diff);

  always_latch begin
    if (!clk) req_hold = req;
  end

  assign gclk = clk & req_hold;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) pulse_cnt <= '0;
    else        pulse_cnt <= pulse_cnt + 1'b1;
  end

  p_load_on_diff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && d != q) |=> q == $past(d));

  p_hold_on_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d == q) |=> ($stable(q) && $stable(pulse_cnt)));

  p_one_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && d != q) |=> pulse_cnt == CNT_W'($past(pulse_cnt) + 1'b1));

  p_enable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q) && $stable(pulse_cnt)));

  p_reset_clear_r6: assert property (@(posedge clk)
    !rst_n |-> (q == '0 && pulse_cnt == '0));

endmodule

// File: tb/sim_dd_gated_reg.sv
module sim_dd_gated_reg;
  localparam int W  = 8;
  localparam int CW = 16;
  localparam int NV = 16;
  // each entry: {en, d}
  localparam logic [W:0] VEC [0:NV-1] = '{
    9'h1_01, 9'h1_01, 9'h1_80, 9'h0_55, 9'h0_80, 9'h1_80,
    9'h1_81, 9'h1_FF, 9'h1_FF, 9'h0_00, 9'h1_00, 9'h1_10,
    9'h1_10, 9'h0_AA, 9'h1_AA, 9'h1_AB};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic [CW-1:0] pulse_cnt;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [W-1:0] ref_q = '0;
  logic [CW-1:0] ref_cnt = '0;

  always #10 clk = ~clk;

  dd_gated_reg #(.WIDTH(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .d(d), .q(q), .pulse_cnt(pulse_cnt));

  task automatic check(input string req, input logic [W-1:0] eq, input logic [CW-1:0] ec);
    checks++;
    if (q !== eq || pulse_cnt !== ec) begin
      errors++;
      $display("FAIL %s: q=%h cnt=%0d expected q=%h cnt=%0d", req, q, pulse_cnt, eq, ec);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    d = 8'h3C;
    #5;
    check("R6 reset state", '0, '0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    d = 8'h00;
    @(negedge clk);
    check("R2 equal after reset", '0, '0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      en = VEC[i][W];
      d  = VEC[i][W-1:0];
      if (!en) tag = "R5 enable low";
      else if (d != ref_q) tag = "R1 R3 changed word";
      else tag = "R2 equal word";
      if (en && d != ref_q) begin
        ref_q = d;
        ref_cnt = ref_cnt + 1'b1;
      end
      @(negedge clk);
      check(tag, ref_q, ref_cnt);
    end

    en = 1'b1;
    d = ref_q;
    @(posedge clk);
    #3 d = ~ref_q;
    #3 d = ref_q ^ 8'h01;
    #3 d = ref_q;
    @(negedge clk);
    check("R4 mid-phase change with no request", ref_q, ref_cnt);

    d = ref_q ^ 8'hF0;
    @(posedge clk);
    #3 d = ref_q;
    ref_q = ref_q ^ 8'hF0;
    ref_cnt = ref_cnt + 1'b1;
    #3 d = ref_q;
    @(negedge clk);
    check("R4 mid-phase return after request", ref_q, ref_cnt);

    d = 8'h00;
    @(negedge clk);
    ref_q = 8'h00;
    ref_cnt = ref_cnt + 1'b1;
    check("R1 R3 single bit-range change", ref_q, ref_cnt);

    for (int k = 0; k < W; k++) begin
      d = ref_q ^ (8'h01 << k);
      ref_q = d;
      ref_cnt = ref_cnt + 1'b1;
      @(negedge clk);
      check("R1 R3 one-bit difference", ref_q, ref_cnt);
    end

    while (ref_cnt != '1) begin
      d = ~d;
      ref_q = d;
      ref_cnt = ref_cnt + 1'b1;
      @(negedge clk);
    end
    check("R7 counter at maximum", ref_q, ref_cnt);
    d = ~d;
    ref_q = d;
    ref_cnt = ref_cnt + 1'b1;
    @(negedge clk);
    check("R7 counter wraps to zero", ref_q, ref_cnt);

    d = 8'h5A;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check("R6 asynchronous clear", '0, '0);
    d = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 R2 after reset release", '0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule